// File: doc/BRIEF.md
# Chip-Select Bank Controller with Write Protection

This block sits between a simple synchronous bus master and a handful of memory banks. For each bus cycle it compares the address against every bank's base address under that bank's mask. It picks one bank and produces a chip-select strobe for it and a transfer acknowledge. Each bank has an attribute word that holds a valid flag, a write-protect flag, a read-parity check enable and an early chip-select release option for writes. Banks are set up through a separate register port. The same port also reads back a sticky status word that records write-protect violations and read parity errors.

The block's clock runs at twice the bus rate, so one clock is one phase. A serviced access always takes four phases. Chip select is high in phases 1 to 4, or in phases 1 to 3 for a write with early release, and acknowledge is high in phase 3. Several kinds of access get no chip select and no acknowledge: one that hits no valid bank, and a write to a write-protected bank. These are left for an external bus monitor to time out. A protected write also sets a sticky flag. A read from a bank with parity checking on is checked in phase 3. On a mismatch the block pulses a bus-error output and sets a sticky flag.

Top module: `csbank_ctrl`

## Requirements
- R1: A bank matches when `((bus_addr ^ base) & mask) == 0`. Base is attribute-word bits [31:4] at register address 2*i. Mask is bits [27:0] at address 2*i+1.
- R2: When several valid banks match, only the lowest-numbered one is strobed, and at most one chip select is high at any time.
- R3: A bank whose valid flag (attribute bit 0) is 0 never has its chip select asserted.
- R4: An access that matches no valid bank gets no chip select and no acknowledge for as long as the request is held.
- R5: When a bank's write-protect flag (attribute bit 1) is 1, its reads are serviced normally. Its writes get no chip select and no acknowledge.
- R6: A write to a write-protected bank sets status bit 0 (status register at address 2*NB). Writing 1 to that bit clears it.
- R7: When a bank's parity enable (attribute bit 2) is 1 and the read data in phase 3 do not satisfy `rd_par == ^rd_data`, the block does two things. It holds `berr_o` high for exactly phase 4, and it sets status bit 1. Writing 1 to status bit 1 clears it.
- R8: When parity enable is 0, read parity is not checked: no bus error, and status bit 1 is unchanged.
- R9: A serviced access has chip select high in phases 1 through 4 and acknowledge high in phase 3 only. Phase k is the k-th clock after the edge that samples the request.
- R10: With early release (attribute bit 3) set, a write has chip select high only in phases 1 through 3, while acknowledge stays in phase 3 and the cycle length is unchanged. Reads are unaffected.
- R11: For an access flagged asynchronous (`bus_async_i`), the early release option is ignored and parity is not checked.
- R12: After reset, bank 0 is valid if and only if `gcs_en_i` is high. All other attribute, base and mask registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock (twice the bus rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| gcs_en_i | input | 1 | Makes bank 0 valid out of reset |
| cfg_we_i | input | 1 | Register port write enable |
| cfg_addr_i | input | CAW | Register port address |
| cfg_wdata_i | input | CW | Register port write data |
| cfg_rdata_o | output | CW | Register port read data (combinational) |
| bus_req_i | input | 1 | Bus cycle strobe, held by the master |
| bus_addr_i | input | AW | Bus address |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_async_i | input | 1 | Access comes from an asynchronous external master |
| rd_data_i | input | DW | Read data returned by the bank |
| rd_par_i | input | 1 | Parity bit for read data (must equal XOR of data) |
| cs_o | output | NB | One chip select per bank |
| ack_o | output | 1 | Transfer acknowledge |
| berr_o | output | 1 | One-phase bus error on a read parity failure |

## Verification
A wrong decode or priority state shows up in phase 1 as the wrong chip-select bit, one clock after the request is sampled. A corrupted phase counter or early-release flag shows up by phase 4 as acknowledge outside phase 3 or chip select dropping at the wrong point. Sticky status faults can be read through the register port right after the offending access. A lost parity capture appears as a missing or misplaced `berr_o` pulse in phase 4.

// File: rtl/csbank_pkg.sv
package csbank_pkg;

    // Per-bank attribute flags; bit 0 is the lowest field of the attribute word.
    typedef struct packed {
        logic early;   // bit 3: release chip select one phase early on writes
        logic par_en;  // bit 2: check read parity
        logic wprot;   // bit 1: reads only
        logic valid;   // bit 0: bank enabled
    } bank_attr_t;

    localparam int ATTR_W = $bits(bank_attr_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD
    } seq_state_e;

endpackage

// File: rtl/csbank_regs.sv
module csbank_regs
    import csbank_pkg::*;
#(
    parameter int NB  = 4,
    parameter int AW  = 28,
    parameter int CAW = 4,
    parameter int CW  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         gcs_en_i,
    input  logic                         cfg_we_i,
    input  logic [CAW-1:0]               cfg_addr_i,
    input  logic [CW-1:0]                cfg_wdata_i,
    output logic [CW-1:0]                cfg_rdata_o,
    input  logic                         set_wp_i,
    input  logic                         set_par_i,
    output logic [NB-1:0][AW-1:0]        base_o,
    output logic [NB-1:0][AW-1:0]        mask_o,
    output bank_attr_t [NB-1:0]          attr_o
);

    localparam int STAT_ADDR = 2 * NB;

    typedef struct packed {
        logic [NB-1:0][AW-1:0] base;
        logic [NB-1:0][AW-1:0] mask;
        bank_attr_t [NB-1:0]   attr;
        logic                  wp_err;
        logic                  par_err;
    } regs_t;

    regs_t regs_d, regs_q, regs_rst;

    always_comb begin
        regs_rst = '0;
        regs_rst.attr[0].valid = gcs_en_i;
    end

    always_comb begin
        regs_d = regs_q;
        if (cfg_we_i) begin
            for (int i = 0; i < NB; i++) begin
                if (cfg_addr_i == CAW'(2 * i)) begin
                    regs_d.base[i] = cfg_wdata_i[CW-1 -: AW];
                    regs_d.attr[i] = bank_attr_t'(cfg_wdata_i[ATTR_W-1:0]);
                end
                if (cfg_addr_i == CAW'(2 * i + 1)) begin
                    regs_d.mask[i] = cfg_wdata_i[AW-1:0];
                end
            end
            if (cfg_addr_i == CAW'(STAT_ADDR)) begin
                if (cfg_wdata_i[0]) regs_d.wp_err  = 1'b0;
                if (cfg_wdata_i[1]) regs_d.par_err = 1'b0;
            end
        end
        // a new event in the same cycle as a clear keeps the flag set
        if (set_wp_i)  regs_d.wp_err  = 1'b1;
        if (set_par_i) regs_d.par_err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= regs_rst;
        else        regs_q <= regs_d;
    end

    always_comb begin
        cfg_rdata_o = '0;
        for (int i = 0; i < NB; i++) begin
            if (cfg_addr_i == CAW'(2 * i))     cfg_rdata_o = {regs_q.base[i], regs_q.attr[i]};
            if (cfg_addr_i == CAW'(2 * i + 1)) cfg_rdata_o = CW'(regs_q.mask[i]);
        end
        if (cfg_addr_i == CAW'(STAT_ADDR)) cfg_rdata_o = CW'({regs_q.par_err, regs_q.wp_err});
    end

    assign base_o = regs_q.base;
    assign mask_o = regs_q.mask;
    assign attr_o = regs_q.attr;

    // R6
    wp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wp_i |=> regs_q.wp_err);

    // R7
    par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_par_i |=> regs_q.par_err);

endmodule

// File: rtl/csbank_match.sv
module csbank_match
    import csbank_pkg::*;
#(
    parameter int NB = 4,
    parameter int AW = 28,
    parameter int BW = 2
) (
    input  logic [AW-1:0]          addr_i,
    input  logic [NB-1:0][AW-1:0]  base_i,
    input  logic [NB-1:0][AW-1:0]  mask_i,
    input  bank_attr_t [NB-1:0]    attr_i,
    output logic                   hit_o,
    output logic [BW-1:0]          idx_o,
    output bank_attr_t             sel_attr_o
);

    logic [NB-1:0] hit_vec;

    for (genvar g = 0; g < NB; g++) begin : g_cmp
        assign hit_vec[g] = attr_i[g].valid && (((addr_i ^ base_i[g]) & mask_i[g]) == '0);
    end

    // lowest-numbered matching bank wins
    always_comb begin
        idx_o = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx_o = BW'(i);
        end
    end

    assign hit_o      = |hit_vec;
    assign sel_attr_o = attr_i[idx_o];

    // R2
    sel_is_hit_chk: assert final (!hit_o || hit_vec[idx_o]);

endmodule

// File: rtl/csbank_seq.sv
module csbank_seq
    import csbank_pkg::*;
#(
    parameter int NB = 4,
    parameter int BW = 2,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic           we_i,
    input  logic           async_i,
    input  logic           hit_i,
    input  logic [BW-1:0]  idx_i,
    input  bank_attr_t     attr_i,
    input  logic [DW-1:0]  rd_data_i,
    input  logic           rd_par_i,
    output logic [NB-1:0]  cs_o,
    output logic           ack_o,
    output logic           berr_o,
    output logic           set_wp_o,
    output logic           set_par_o
);

    localparam logic [2:0] PH_ACK  = 3'd3;
    localparam logic [2:0] PH_LAST = 3'd4;

    typedef struct packed {
        seq_state_e      st;
        logic [2:0]      ph;
        logic [BW-1:0]   bank;
        logic            early;
        logic            par;
        logic [NB-1:0]   cs;
        logic            ack;
        logic            berr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic par_bad;

    assign par_bad = (^rd_data_i) != rd_par_i;

    always_comb begin
        seq_d      = seq_q;
        seq_d.cs   = '0;
        seq_d.ack  = 1'b0;
        seq_d.berr = 1'b0;
        set_wp_o   = 1'b0;
        set_par_o  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    if (hit_i && !(we_i && attr_i.wprot)) begin
                        seq_d.st          = ST_RUN;
                        seq_d.ph          = 3'd1;
                        seq_d.bank        = idx_i;
                        seq_d.early       = we_i && attr_i.early && !async_i;
                        seq_d.par         = !we_i && attr_i.par_en && !async_i;
                        seq_d.cs[idx_i]   = 1'b1;
                    end else begin
                        // unserviced: wait for the master to give up
                        seq_d.st = ST_HOLD;
                        set_wp_o = hit_i && we_i && attr_i.wprot;
                    end
                end
            end
            ST_RUN: begin
                if (seq_q.ph == PH_LAST) begin
                    seq_d.st = ST_HOLD;
                    seq_d.ph = '0;
                end else begin
                    seq_d.ph            = seq_q.ph + 3'd1;
                    seq_d.cs[seq_q.bank] = !(seq_d.ph == PH_LAST && seq_q.early);
                    seq_d.ack           = (seq_d.ph == PH_ACK);
                end
                if (seq_q.ph == PH_ACK && seq_q.par && par_bad) begin
                    seq_d.berr = 1'b1;
                    set_par_o  = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!req_i) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign cs_o   = seq_q.cs;
    assign ack_o  = seq_q.ack;
    assign berr_o = seq_q.berr;

    // R2
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    // R9
    ack_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (|cs_o));

    // R9
    ack_one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R7
    berr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        berr_o |=> !berr_o);

endmodule

// File: rtl/csbank_ctrl.sv
module csbank_ctrl
    import csbank_pkg::*;
#(
    parameter  int NB  = 4,
    parameter  int AW  = 28,
    parameter  int DW  = 32,
    localparam int BW  = $clog2(NB),
    localparam int CAW = $clog2(2 * NB + 1),
    localparam int CW  = AW + ATTR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gcs_en_i,
    input  logic            cfg_we_i,
    input  logic [CAW-1:0]  cfg_addr_i,
    input  logic [CW-1:0]   cfg_wdata_i,
    output logic [CW-1:0]   cfg_rdata_o,
    input  logic            bus_req_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic            bus_we_i,
    input  logic            bus_async_i,
    input  logic [DW-1:0]   rd_data_i,
    input  logic            rd_par_i,
    output logic [NB-1:0]   cs_o,
    output logic            ack_o,
    output logic            berr_o
);

    logic [NB-1:0][AW-1:0] base_w, mask_w;
    bank_attr_t [NB-1:0]   attr_w;
    bank_attr_t            sel_attr_w;
    logic                  hit_w, set_wp_w, set_par_w;
    logic [BW-1:0]         idx_w;

    csbank_regs #(.NB(NB), .AW(AW), .CAW(CAW), .CW(CW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .gcs_en_i    (gcs_en_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o),
        .set_wp_i    (set_wp_w),
        .set_par_i   (set_par_w),
        .base_o      (base_w),
        .mask_o      (mask_w),
        .attr_o      (attr_w)
    );

    csbank_match #(.NB(NB), .AW(AW), .BW(BW)) u_match (
        .addr_i     (bus_addr_i),
        .base_i     (base_w),
        .mask_i     (mask_w),
        .attr_i     (attr_w),
        .hit_o      (hit_w),
        .idx_o      (idx_w),
        .sel_attr_o (sel_attr_w)
    );

    csbank_seq #(.NB(NB), .BW(BW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (bus_req_i),
        .we_i      (bus_we_i),
        .async_i   (bus_async_i),
        .hit_i     (hit_w),
        .idx_i     (idx_w),
        .attr_i    (sel_attr_w),
        .rd_data_i (rd_data_i),
        .rd_par_i  (rd_par_i),
        .cs_o      (cs_o),
        .ack_o     (ack_o),
        .berr_o    (berr_o),
        .set_wp_o  (set_wp_w),
        .set_par_o (set_par_w)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank_chk
        // R3
        cs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cs_o[g]) |-> $past(attr_w[g].valid));

        // R5
        cs_wprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(cs_o[g]) && $past(bus_we_i)) |-> !$past(attr_w[g].wprot));
    end

endmodule

// File: tb/csbank_ctrl_bench.sv
module csbank_ctrl_bench;

    localparam int CLK_P = 10;
    localparam int NB    = 4;
    localparam int AW    = 28;
    localparam int DW    = 32;
    localparam int CAW   = 4;
    localparam int CW    = 32;
    localparam int STAT  = 8;

    localparam logic [3:0] F_V  = 4'h1;
    localparam logic [3:0] F_WP = 4'h2;
    localparam logic [3:0] F_PE = 4'h4;
    localparam logic [3:0] F_EN = 4'h8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            gcs_en = 1'b0;
    logic            cfg_we = 1'b0;
    logic [CAW-1:0]  cfg_addr = '0;
    logic [CW-1:0]   cfg_wdata = '0;
    logic [CW-1:0]   cfg_rdata;
    logic            bus_req = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic            bus_async = 1'b0;
    logic [DW-1:0]   rd_data = '0;
    logic            rd_par = 1'b0;
    logic [NB-1:0]   cs;
    logic            ack, berr;

    int n_chk = 0;
    int n_err = 0;

    logic [NB-1:0] cs_h [1:6];
    logic          ack_h [1:6];
    logic          berr_h [1:6];

    always #(CLK_P / 2) clk = ~clk;

    csbank_ctrl u_csbank_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .gcs_en_i    (gcs_en),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .bus_req_i   (bus_req),
        .bus_addr_i  (bus_addr),
        .bus_we_i    (bus_we),
        .bus_async_i (bus_async),
        .rd_data_i   (rd_data),
        .rd_par_i    (rd_par),
        .cs_o        (cs),
        .ack_o       (ack),
        .berr_o      (berr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic do_reset(input logic gcs);
        @(negedge clk);
        rst_n  = 1'b0;
        gcs_en = gcs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_wr(input int a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CAW'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input int a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = CAW'(a);
        #1 v = cfg_rdata;
    endtask

    task automatic set_bank(input int b, input logic [27:0] base, input logic [27:0] mask, input logic [3:0] fl);
        cfg_wr(2 * b, {base, fl});
        cfg_wr(2 * b + 1, {4'h0, mask});
    endtask

    // request held through phase 3, outputs sampled mid-phase
    task automatic access(input logic [27:0] a, input logic we, input logic asy);
        @(negedge clk);
        bus_req = 1'b1; bus_addr = a; bus_we = we; bus_async = asy;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            cs_h[k] = cs; ack_h[k] = ack; berr_h[k] = berr;
            if (k == 3) bus_req = 1'b0;
        end
    endtask

    // bank < 0 means no service expected
    task automatic expect_cycle(input string tag, input int bank, input bit early, input bit berr_e);
        for (int k = 1; k <= 6; k++) begin
            logic [NB-1:0] cs_e;
            cs_e = (bank >= 0 && k <= (early ? 3 : 4)) ? NB'(1 << bank) : '0;
            chk($sformatf("%s cs phase %0d", tag, k), 32'(cs_h[k]), 32'(cs_e));
            chk($sformatf("%s ack phase %0d", tag, k), 32'(ack_h[k]), 32'(bank >= 0 && k == 3));
            chk($sformatf("%s berr phase %0d", tag, k), 32'(berr_h[k]), 32'(berr_e && k == 4));
        end
    endtask

    task automatic t_reset_no_gcs();
        logic [31:0] v;
        do_reset(1'b0);
        cfg_rd(0, v);
        chk("R12 bank0 attr without gcs", v, 32'h0);
        access(28'h0000010, 1'b0, 1'b0);
        expect_cycle("R12 R4 access with no valid bank", -1, 0, 0);
    endtask

    task automatic t_reset_defaults();
        logic [31:0] v;
        do_reset(1'b1);
        cfg_rd(0, v);
        chk("R12 bank0 attr with gcs", v, 32'h1);
        cfg_rd(1, v);
        chk("R12 bank0 mask", v, 32'h0);
        cfg_rd(2, v);
        chk("R12 bank1 attr", v, 32'h0);
        cfg_rd(STAT, v);
        chk("R12 status", v, 32'h0);
        access(28'h5555555, 1'b0, 1'b0);
        expect_cycle("R12 R9 default bank0 read", 0, 0, 0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        set_bank(0, 28'h1000000, 28'hF000000, F_V);
        set_bank(1, 28'h2000000, 28'hF000000, F_V);
        set_bank(2, 28'h2010000, 28'hFFF0000, F_V | F_PE);
        set_bank(3, 28'h3000000, 28'hF000000, 4'h0);
        cfg_rd(4, v);
        chk("R1 bank2 attr readback", v, {28'h2010000, F_V | F_PE});
        access(28'h1234567, 1'b0, 1'b0);
        expect_cycle("R1 R9 read bank0", 0, 0, 0);
        access(28'h2012345, 1'b0, 1'b0);
        expect_cycle("R2 overlap picks bank1", 1, 0, 0);
        access(28'h3000040, 1'b0, 1'b0);
        expect_cycle("R3 invalid bank3", -1, 0, 0);
        access(28'h7000000, 1'b0, 1'b0);
        expect_cycle("R4 no match", -1, 0, 0);
        set_bank(1, 28'h2000000, 28'hF000000, 4'h0);
        access(28'h2012345, 1'b0, 1'b0);
        expect_cycle("R1 R3 bank1 off falls to bank2", 2, 0, 0);
        access(28'h2020000, 1'b0, 1'b0);
        expect_cycle("R1 mask excludes bank2", -1, 0, 0);
    endtask

    task automatic t_write_timing();
        access(28'h1000100, 1'b1, 1'b0);
        expect_cycle("R9 write bank0", 0, 0, 0);
    endtask

    task automatic t_early();
        set_bank(0, 28'h1000000, 28'hF000000, F_V | F_EN);
        access(28'h1000100, 1'b1, 1'b0);
        expect_cycle("R10 early write", 0, 1, 0);
        access(28'h1000100, 1'b0, 1'b0);
        expect_cycle("R10 early read unaffected", 0, 0, 0);
        access(28'h1000100, 1'b1, 1'b1);
        expect_cycle("R11 async write ignores early", 0, 0, 0);
    endtask

    task automatic t_wprotect();
        logic [31:0] v;
        set_bank(0, 28'h1000000, 28'hF000000, F_V | F_WP);
        cfg_rd(STAT, v);
        chk("R6 status clear before", v, 32'h0);
        access(28'h1000200, 1'b1, 1'b0);
        expect_cycle("R5 protected write dropped", -1, 0, 0);
        cfg_rd(STAT, v);
        chk("R6 wp error set", v, 32'h1);
        access(28'h1000200, 1'b0, 1'b0);
        expect_cycle("R5 protected read serviced", 0, 0, 0);
        cfg_wr(STAT, 32'h0);
        cfg_rd(STAT, v);
        chk("R6 writing 0 keeps flag", v, 32'h1);
        cfg_wr(STAT, 32'h1);
        cfg_rd(STAT, v);
        chk("R6 write-1 clears flag", v, 32'h0);
    endtask

    task automatic t_parity();
        logic [31:0] v;
        rd_data = 32'h0000_0001; rd_par = 1'b0;
        access(28'h2011111, 1'b0, 1'b0);
        expect_cycle("R7 bad parity bank2", 2, 0, 1);
        cfg_rd(STAT, v);
        chk("R7 parity error flag", v, 32'h2);
        cfg_wr(STAT, 32'h2);
        cfg_rd(STAT, v);
        chk("R7 parity flag cleared", v, 32'h0);
        rd_data = 32'h0000_0003; rd_par = 1'b0;
        access(28'h2011111, 1'b0, 1'b0);
        expect_cycle("R7 good parity bank2", 2, 0, 0);
        rd_data = 32'h0000_0001; rd_par = 1'b0;
        access(28'h1000000, 1'b0, 1'b0);
        expect_cycle("R8 bank0 no parity check", 0, 0, 0);
        access(28'h2011111, 1'b0, 1'b1);
        expect_cycle("R11 async read skips parity", 2, 0, 0);
        cfg_rd(STAT, v);
        chk("R8 R11 status untouched", v, 32'h0);
    endtask

    initial begin
        t_reset_no_gcs();
        t_reset_defaults();
        t_decode();
        t_write_timing();
        t_early();
        t_wprotect();
        t_parity();
        report();
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

endmodule